// File: doc/BRIEF.md
# ATA Device Task-File Status Controller

This block is the register file a parallel ATA target presents to the host. It holds the command parameter registers, the command and status port, the alternate status and device control port, and the logic that drives the busy, ready, data-request and error flags. The host reaches it over a simple register bus: a chip select, a block select, a 3-bit address, read and write strobes, and a 16-bit data path. The read data is combinational, so it is valid in the same cycle as the read strobe. A write or a read side effect takes effect at the following clock edge.

A command write copies the parameter registers into a latch that the back-end command engine reads. The block then pulses `cmd_start`. The engine answers with a completion pulse, an error pulse with an error code, or a data-ready pulse that opens a programmed-I/O data phase. In that phase a word counter counts data-register accesses. The data request drops after one 256-word sector, or after the configured multiple-block size when `be_multi` is high. SET MULTIPLE (code C6h) is handled inside the block.

The controller states are RESET_WAIT (ST_RST), SOFT_RESET (ST_SRST), IDLE (ST_IDLE), EXECUTE (ST_EXEC), SETMULT_EVAL (ST_SETM) and DATA_PHASE (ST_DRQ). The transitions are as follows:
- A soft-reset write moves every state to SOFT_RESET.
- SOFT_RESET goes to RESET_WAIT when the soft-reset bit is written back to zero.
- RESET_WAIT goes to IDLE after `RST_CYCLES` clocks and loads the signature.
- IDLE goes to EXECUTE on a command write, or to SETMULT_EVAL when the command is C6h.
- EXECUTE goes to IDLE on an error pulse or a completion pulse, or to DATA_PHASE on a data-ready pulse.
- SETMULT_EVAL goes to IDLE after one cycle.
- DATA_PHASE goes to EXECUTE on the last counted word.

Top module: `ata_taskfile_ctrl`

## Requirements
- R1: After hardware reset is released, status reads BSY=1 and DRDY=0. After `RST_CYCLES` clocks it reads 0x40 (BSY=0, DRDY=1). Sector count and sector number then read 1, both cylinder bytes read 0, and the error register reads 01h.
- R2: A command write (address 7) in IDLE has these effects one cycle later:
  - the parameter outputs show the register contents at the time of the write;
  - `cmd_code` shows the written code;
  - `cmd_start` is high for exactly one cycle;
  - BSY is 1.
- R3: While BSY=1, every command-block read returns 0x0080, and command-block register writes have no effect.
- R4: A device-control write with bit 2 = 1 gives BSY=1, DRDY=0 and ERR=0 and clears the pending interrupt. Writing bit 2 = 0 starts the R1 reset sequence, after which the signature values are back.
- R5: A data-ready pulse in EXECUTE gives status 0x48 (DRQ is bit 3) and raises the interrupt. While DRQ=1, data-register reads return `pio_data`.
- R6: DRQ stays 1 for 256 x N data-register accesses, then drops with BSY=1. N is 1, or the multiple-block size when `be_multi` was high with the data-ready pulse.
- R7: A completion pulse in EXECUTE clears BSY and raises the pending interrupt.
- R8: An error pulse in EXECUTE gives the following: ERR=1 (bit 0), `be_err_code` in the error register (address 1), and the failed command's parameters still in the count, sector and cylinder registers.
- R9: A new command write clears ERR.
- R10: An alternate-status read (block select 1, address 6) returns the status value and leaves the interrupt pending. A status read (address 7) clears the pending interrupt.
- R11: `intrq` is the pending interrupt masked by device-control bit 1. Clearing the mask shows an interrupt that is still pending.
- R12: SET MULTIPLE (C6h) does not pulse `cmd_start`. A count of 2, 4, 8, 16, 32, 64 or 128 becomes the multiple-block size. Any other count sets ERR, loads 04h into the error register and leaves the size unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| cs | input | 1 | Register bus select |
| blk_sel | input | 1 | 0 selects the command block, 1 selects the control block |
| addr | input | 3 | Register address |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational |
| intrq | output | 1 | Interrupt request |
| cmd_start | output | 1 | One-cycle command start to the engine |
| cmd_code | output | 8 | Latched command code |
| prm_feature | output | 8 | Latched feature parameter |
| prm_count | output | 8 | Latched sector count |
| prm_sector | output | 8 | Latched sector number |
| prm_cyl | output | 16 | Latched cylinder, high byte above low byte |
| prm_devhead | output | 8 | Latched device/head |
| be_done | input | 1 | Engine completion pulse |
| be_error | input | 1 | Engine error pulse |
| be_err_code | input | 8 | Error register value that goes with be_error |
| be_data_rdy | input | 1 | Engine ready for a PIO data block |
| be_multi | input | 1 | The data block uses the multiple-block size |
| pio_data | input | 16 | Data word returned on data-register reads |
| data_xfer | output | 1 | A counted data-register access in this cycle |

## Verification
The assertions check four things on every cycle: that a command start only appears while busy, that DRQ rises only after a data-ready pulse and always falls into busy, that ERR rises only out of a busy state, and that soft reset forces busy with ERR cleared. They also check that an alternate-status read never drops a pending interrupt and that a count write during execution leaves the register unchanged.

Only the bench scenarios can show the rest, because it depends on values and counts across many cycles:
- the exact read values;
- the signature after each reset;
- the 256-word and 512-word data-phase lengths;
- error-context retention;
- whether the multiple-block size survives a rejected SET MULTIPLE.

// File: rtl/ata_tf_pkg.sv
package ata_tf_pkg;

    typedef enum logic [2:0] {
        ST_RST  = 3'd0,
        ST_SRST = 3'd1,
        ST_IDLE = 3'd2,
        ST_EXEC = 3'd3,
        ST_SETM = 3'd4,
        ST_DRQ  = 3'd5
    } tf_state_e;

    typedef struct packed {
        logic [7:0] feature;
        logic [7:0] count;
        logic [7:0] sector;
        logic [7:0] cyl_lo;
        logic [7:0] cyl_hi;
        logic [7:0] devhead;
    } tf_regs_t;

    localparam logic [2:0] A_DATA    = 3'd0;
    localparam logic [2:0] A_ERRFEAT = 3'd1;
    localparam logic [2:0] A_COUNT   = 3'd2;
    localparam logic [2:0] A_SECTOR  = 3'd3;
    localparam logic [2:0] A_CYLLO   = 3'd4;
    localparam logic [2:0] A_CYLHI   = 3'd5;
    localparam logic [2:0] A_DEVHEAD = 3'd6;
    localparam logic [2:0] A_STATCMD = 3'd7;
    localparam logic [2:0] A_CTRL    = 3'd6;

    localparam logic [7:0] CMD_SETMULT = 8'hC6;
    localparam logic [7:0] ERR_ABORT   = 8'h04;
    localparam logic [7:0] ERR_SIGN    = 8'h01;

    localparam int CTL_NIEN_BIT = 1;
    localparam int CTL_SRST_BIT = 2;

endpackage

// File: rtl/ata_tf_fsm.sv
module ata_tf_fsm
    import ata_tf_pkg::*;
#(
    parameter int RST_CYCLES = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      srst_set,
    input  logic      srst_clr,
    input  logic      cmd_we,
    input  logic      cmd_is_setm,
    input  logic      setm_ok,
    input  logic      be_done,
    input  logic      be_error,
    input  logic      be_data_rdy,
    input  logic      blk_last,
    output tf_state_e state,
    output logic      sig_load,
    output logic      go_drq,
    output logic      fin_ok,
    output logic      fin_err
);

    localparam int RCW = $clog2(RST_CYCLES + 1);

    tf_state_e      nxt;
    logic [RCW-1:0] rcnt;
    logic           rst_done;

    assign rst_done = (rcnt == RCW'(RST_CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RST;
            rcnt  <= '0;
        end else begin
            state <= nxt;
            rcnt  <= (state == ST_RST && !srst_set && !rst_done) ? rcnt + 1'b1 : '0;
        end
    end

    always_comb begin
        nxt = state;
        if (srst_set) begin
            nxt = ST_SRST;
        end else begin
            unique case (state)
                ST_RST:  if (rst_done) nxt = ST_IDLE;
                ST_SRST: if (srst_clr) nxt = ST_RST;
                ST_IDLE: if (cmd_we) nxt = cmd_is_setm ? ST_SETM : ST_EXEC;
                ST_EXEC: begin
                    if (be_error || be_done) nxt = ST_IDLE;
                    else if (be_data_rdy)    nxt = ST_DRQ;
                end
                ST_SETM: nxt = ST_IDLE;
                ST_DRQ:  if (blk_last) nxt = ST_EXEC;
                default: nxt = ST_RST;
            endcase
        end
    end

    always_comb begin
        sig_load = !srst_set && (state == ST_RST) && rst_done;
        go_drq   = !srst_set && (state == ST_EXEC) && !be_error && !be_done && be_data_rdy;
        fin_ok   = !srst_set && (((state == ST_EXEC) && !be_error && be_done) ||
                                 ((state == ST_SETM) && setm_ok));
        fin_err  = !srst_set && (((state == ST_EXEC) && be_error) ||
                                 ((state == ST_SETM) && !setm_ok));
    end

endmodule

// File: rtl/ata_tf_regs.sv
module ata_tf_regs
    import ata_tf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_we,
    input  logic [2:0] reg_sel,
    input  logic [7:0] wval,
    input  logic       cmd_we,
    input  logic       sig_load,
    input  logic       err_load,
    input  logic [7:0] err_val,
    output tf_regs_t   cur,
    output tf_regs_t   prm,
    output logic [7:0] err_reg
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur     <= '0;
            prm     <= '0;
            err_reg <= '0;
        end else begin
            if (sig_load) begin
                cur.count   <= 8'd1;
                cur.sector  <= 8'd1;
                cur.cyl_lo  <= 8'd0;
                cur.cyl_hi  <= 8'd0;
                cur.devhead <= 8'd0;
            end else if (reg_we) begin
                unique case (reg_sel)
                    A_ERRFEAT: cur.feature <= wval;
                    A_COUNT:   cur.count   <= wval;
                    A_SECTOR:  cur.sector  <= wval;
                    A_CYLLO:   cur.cyl_lo  <= wval;
                    A_CYLHI:   cur.cyl_hi  <= wval;
                    A_DEVHEAD: cur.devhead <= wval;
                    default:   ;
                endcase
            end
            if (cmd_we) prm <= cur;
            if (sig_load)      err_reg <= ERR_SIGN;
            else if (err_load) err_reg <= err_val;
        end
    end

endmodule

// File: rtl/ata_tf_wordcnt.sv
module ata_tf_wordcnt #(
    parameter int WORDS    = 256,
    parameter int MAX_SECT = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] sectors,
    input  logic       step,
    output logic       last
);

    localparam int CW = $clog2(WORDS * MAX_SECT);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            lim <= '0;
        end else if (start) begin
            cnt <= '0;
            lim <= CW'(int'(sectors) * WORDS - 1);
        end else if (step) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = step && (cnt == lim);

endmodule

// File: rtl/ata_taskfile_ctrl.sv
module ata_taskfile_ctrl
    import ata_tf_pkg::*;
#(
    parameter int WORDS_PER_SECT = 256,
    parameter int MAX_SECT       = 128,
    parameter int RST_CYCLES     = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs,
    input  logic        blk_sel,
    input  logic [2:0]  addr,
    input  logic        rd,
    input  logic        wr,
    input  logic [15:0] wdata,
    output logic [15:0] rdata,
    output logic        intrq,
    output logic        cmd_start,
    output logic [7:0]  cmd_code,
    output logic [7:0]  prm_feature,
    output logic [7:0]  prm_count,
    output logic [7:0]  prm_sector,
    output logic [15:0] prm_cyl,
    output logic [7:0]  prm_devhead,
    input  logic        be_done,
    input  logic        be_error,
    input  logic [7:0]  be_err_code,
    input  logic        be_data_rdy,
    input  logic        be_multi,
    input  logic [15:0] pio_data,
    output logic        data_xfer
);

    tf_state_e  state;
    tf_regs_t   cur, prm;
    logic [7:0] err_reg, mult_size, sel_sect, err_val, status;
    logic       bsy, drq, drdy, err_q, intr_pend, nien, exec_st;
    logic       wr_cb, rd_cb, ctl_wr, srst_set, srst_clr, reg_we, cmd_we;
    logic       cmd_is_setm, setm_ok, status_rd, alt_rd;
    logic       sig_load, go_drq, fin_ok, fin_err, blk_last;

    assign bsy     = (state == ST_RST) || (state == ST_SRST) ||
                     (state == ST_EXEC) || (state == ST_SETM);
    assign drq     = (state == ST_DRQ);
    assign drdy    = (state != ST_RST) && (state != ST_SRST);
    assign exec_st = (state == ST_EXEC);
    assign status  = {bsy, drdy, 2'b00, drq, 2'b00, err_q};

    assign wr_cb       = cs && wr && !blk_sel;
    assign rd_cb       = cs && rd && !blk_sel;
    assign ctl_wr      = cs && wr && blk_sel && (addr == A_CTRL);
    assign srst_set    = ctl_wr && wdata[CTL_SRST_BIT];
    assign srst_clr    = ctl_wr && !wdata[CTL_SRST_BIT];
    assign reg_we      = wr_cb && (state == ST_IDLE) && (addr != A_DATA) && (addr != A_STATCMD);
    assign cmd_we      = wr_cb && (state == ST_IDLE) && (addr == A_STATCMD);
    assign cmd_is_setm = (wdata[7:0] == CMD_SETMULT);
    assign status_rd   = rd_cb && (addr == A_STATCMD);
    assign alt_rd      = cs && rd && blk_sel && (addr == A_CTRL);
    assign data_xfer   = cs && (rd || wr) && !blk_sel && (addr == A_DATA) && drq;
    assign setm_ok     = (prm.count != 8'd0) && (prm.count != 8'd1) &&
                         ((prm.count & (prm.count - 8'd1)) == 8'd0);
    assign err_val     = (state == ST_SETM) ? ERR_ABORT : be_err_code;
    assign sel_sect    = (be_multi && (mult_size != 8'd0)) ? mult_size : 8'd1;

    ata_tf_fsm #(.RST_CYCLES(RST_CYCLES)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .srst_set    (srst_set),
        .srst_clr    (srst_clr),
        .cmd_we      (cmd_we),
        .cmd_is_setm (cmd_is_setm),
        .setm_ok     (setm_ok),
        .be_done     (be_done),
        .be_error    (be_error),
        .be_data_rdy (be_data_rdy),
        .blk_last    (blk_last),
        .state       (state),
        .sig_load    (sig_load),
        .go_drq      (go_drq),
        .fin_ok      (fin_ok),
        .fin_err     (fin_err)
    );

    ata_tf_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_sel  (addr),
        .wval     (wdata[7:0]),
        .cmd_we   (cmd_we),
        .sig_load (sig_load),
        .err_load (fin_err),
        .err_val  (err_val),
        .cur      (cur),
        .prm      (prm),
        .err_reg  (err_reg)
    );

    ata_tf_wordcnt #(.WORDS(WORDS_PER_SECT), .MAX_SECT(MAX_SECT)) u_wcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (go_drq),
        .sectors (sel_sect),
        .step    (data_xfer),
        .last    (blk_last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q     <= 1'b0;
            intr_pend <= 1'b0;
            nien      <= 1'b0;
            mult_size <= 8'd0;
            cmd_start <= 1'b0;
            cmd_code  <= 8'd0;
        end else begin
            cmd_start <= cmd_we && !cmd_is_setm;
            if (cmd_we) cmd_code <= wdata[7:0];
            if (ctl_wr) nien <= wdata[CTL_NIEN_BIT];
            if (srst_set || cmd_we) err_q <= 1'b0;
            else if (fin_err)       err_q <= 1'b1;
            if (srst_set || cmd_we)                 intr_pend <= 1'b0;
            else if (go_drq || fin_ok || fin_err)   intr_pend <= 1'b1;
            else if (status_rd)                     intr_pend <= 1'b0;
            if ((state == ST_SETM) && setm_ok && !srst_set) mult_size <= prm.count;
        end
    end

    assign intrq       = intr_pend && !nien;
    assign prm_feature = prm.feature;
    assign prm_count   = prm.count;
    assign prm_sector  = prm.sector;
    assign prm_cyl     = {prm.cyl_hi, prm.cyl_lo};
    assign prm_devhead = prm.devhead;

    always_comb begin
        rdata = 16'h0000;
        if (cs && rd) begin
            if (blk_sel) begin
                if (addr == A_CTRL) rdata = {8'h00, status};
            end else if (bsy) begin
                rdata = 16'h0080;
            end else begin
                unique case (addr)
                    A_DATA:    rdata = drq ? pio_data : 16'h0000;
                    A_ERRFEAT: rdata = {8'h00, err_reg};
                    A_COUNT:   rdata = {8'h00, cur.count};
                    A_SECTOR:  rdata = {8'h00, cur.sector};
                    A_CYLLO:   rdata = {8'h00, cur.cyl_lo};
                    A_CYLHI:   rdata = {8'h00, cur.cyl_hi};
                    A_DEVHEAD: rdata = {8'h00, cur.devhead};
                    A_STATCMD: rdata = {8'h00, status};
                    default:   rdata = 16'h0000;
                endcase
            end
        end
    end

endmodule

// File: rtl/ata_tf_chk.sv
module ata_tf_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       bsy,
    input logic       drq,
    input logic       err_q,
    input logic       intr_pend,
    input logic       cmd_start,
    input logic       be_data_rdy,
    input logic       srst_set,
    input logic       alt_rd,
    input logic       exec_st,
    input logic       cs,
    input logic       wr,
    input logic       blk_sel,
    input logic [2:0] addr,
    input logic [7:0] cnt
);

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |-> bsy);

    assert_busy_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_st && cs && wr && !blk_sel && addr == 3'd2) |=> $stable(cnt));

    assert_soft_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        srst_set |=> (bsy && !err_q));

    assert_drq_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drq) |-> $past(be_data_rdy));

    assert_drq_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drq) |-> bsy);

    assert_err_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(bsy));

    assert_alt_keeps_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (alt_rd && intr_pend && !wr) |=> intr_pend);

endmodule

bind ata_taskfile_ctrl ata_tf_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bsy         (bsy),
    .drq         (drq),
    .err_q       (err_q),
    .intr_pend   (intr_pend),
    .cmd_start   (cmd_start),
    .be_data_rdy (be_data_rdy),
    .srst_set    (srst_set),
    .alt_rd      (alt_rd),
    .exec_st     (exec_st),
    .cs          (cs),
    .wr          (wr),
    .blk_sel     (blk_sel),
    .addr        (addr),
    .cnt         (cur.count)
);

// File: tb/sim_ata_taskfile_ctrl.sv
`timescale 1ns/1ps
module sim_ata_taskfile_ctrl;

    localparam int RC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 0, blk_sel = 0, rd = 0, wr = 0;
    logic [2:0]  addr = 0;
    logic [15:0] wdata = 0;
    logic [15:0] rdata;
    logic        intrq, cmd_start, data_xfer;
    logic [7:0]  cmd_code, prm_feature, prm_count, prm_sector, prm_devhead;
    logic [15:0] prm_cyl;
    logic        be_done = 0, be_error = 0, be_data_rdy = 0, be_multi = 0;
    logic [7:0]  be_err_code = 0;
    logic [15:0] pio_data = 16'hBEEF;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ata_taskfile_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .blk_sel(blk_sel), .addr(addr),
        .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata), .intrq(intrq),
        .cmd_start(cmd_start), .cmd_code(cmd_code), .prm_feature(prm_feature),
        .prm_count(prm_count), .prm_sector(prm_sector), .prm_cyl(prm_cyl),
        .prm_devhead(prm_devhead), .be_done(be_done), .be_error(be_error),
        .be_err_code(be_err_code), .be_data_rdy(be_data_rdy), .be_multi(be_multi),
        .pio_data(pio_data), .data_xfer(data_xfer)
    );

    // Behavioural reference model. States: 0 reset wait, 1 soft reset, 2 idle,
    // 3 execute, 4 set-multiple evaluation, 5 data phase.
    int         ms = 0, mrc = 0, mwc = 0, mlim = 0;
    bit         merr = 0, mpend = 0, mnien = 0, mstart = 0;
    logic [7:0] mreg [1:6];
    logic [7:0] mprm [1:6];
    logic [7:0] merrreg = 0, mmult = 0, mcode = 0;

    always @(posedge clk) begin
        bit ctlw, cmdw, regw, strd, dx;
        if (!rst_n) begin
            ms = 0; mrc = 0; merr = 0; mpend = 0; mnien = 0; mstart = 0;
            mmult = 0; merrreg = 0; mcode = 0;
            for (int i = 1; i <= 6; i++) begin mreg[i] = 0; mprm[i] = 0; end
        end else begin
            ctlw = cs && wr && blk_sel && addr == 3'd6;
            cmdw = cs && wr && !blk_sel && addr == 3'd7 && ms == 2;
            regw = cs && wr && !blk_sel && addr >= 3'd1 && addr <= 3'd6 && ms == 2;
            strd = cs && rd && !blk_sel && addr == 3'd7;
            dx   = cs && (rd || wr) && !blk_sel && addr == 3'd0 && ms == 5;
            mstart = cmdw && wdata[7:0] != 8'hC6;
            if (regw) mreg[addr] = wdata[7:0];
            if (cmdw) begin mprm = mreg; mcode = wdata[7:0]; end
            if (ctlw) mnien = wdata[1];
            if (strd) mpend = 0;
            if (ctlw && wdata[2]) begin
                ms = 1; merr = 0; mpend = 0; mrc = 0;
            end else begin
                case (ms)
                    0: if (mrc == RC - 1) begin
                           ms = 2; mrc = 0; mreg[2] = 1; mreg[3] = 1; mreg[4] = 0;
                           mreg[5] = 0; mreg[6] = 0; merrreg = 8'h01;
                       end else mrc++;
                    1: if (ctlw) begin ms = 0; mrc = 0; end
                    2: if (cmdw) begin merr = 0; mpend = 0; ms = (wdata[7:0] == 8'hC6) ? 4 : 3; end
                    3: if (be_error) begin ms = 2; merr = 1; mpend = 1; merrreg = be_err_code; end
                       else if (be_done) begin ms = 2; mpend = 1; end
                       else if (be_data_rdy) begin
                           ms = 5; mpend = 1; mwc = 0;
                           mlim = 256 * ((be_multi && mmult != 0) ? int'(mmult) : 1);
                       end
                    4: begin
                           if (mprm[2] inside {8'd2, 8'd4, 8'd8, 8'd16, 8'd32, 8'd64, 8'd128})
                               mmult = mprm[2];
                           else begin merr = 1; merrreg = 8'h04; end
                           ms = 2; mpend = 1;
                       end
                    5: if (dx) begin mwc++; if (mwc == mlim) ms = 3; end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [15:0] exp_rd();
        logic [7:0] st;
        bit b;
        b  = (ms <= 1) || ms == 3 || ms == 4;
        st = {b, ms >= 2, 2'b00, ms == 5, 2'b00, merr};
        if (blk_sel) return (addr == 3'd6) ? {8'h00, st} : 16'h0000;
        if (b) return 16'h0080;
        case (addr)
            3'd0: return (ms == 5) ? pio_data : 16'h0000;
            3'd1: return {8'h00, merrreg};
            3'd7: return {8'h00, st};
            default: return {8'h00, mreg[addr]};
        endcase
    endfunction

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            #2;
            tests++;
            if (intrq !== (mpend && !mnien)) begin
                fails++;
                $display("FAIL REF R7/R11 intrq act=%0b exp=%0b", intrq, mpend && !mnien);
            end
            tests++;
            if (cmd_start !== mstart) begin
                fails++;
                $display("FAIL REF R2 cmd_start act=%0b exp=%0b", cmd_start, mstart);
            end
            if (cs && rd) begin
                tests++;
                if (rdata !== exp_rd()) begin
                    fails++;
                    $display("FAIL REF R3/R5 rdata act=%h exp=%h", rdata, exp_rd());
                end
            end
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic b, input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        cs = 1; blk_sel = b; addr = a; wdata = d; wr = 1;
        @(negedge clk);
        cs = 0; wr = 0; blk_sel = 0; addr = 0; wdata = 0;
    endtask

    task automatic bus_rd(input logic b, input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        cs = 1; blk_sel = b; addr = a; rd = 1;
        #1 d = rdata;
        @(negedge clk);
        cs = 0; rd = 0; blk_sel = 0; addr = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk); be_done = 1;
        @(negedge clk); be_done = 0;
    endtask

    task automatic pulse_data(input logic multi);
        @(negedge clk); be_data_rdy = 1; be_multi = multi;
        @(negedge clk); be_data_rdy = 0; be_multi = 0;
    endtask

    task automatic pulse_error(input logic [7:0] code);
        @(negedge clk); be_error = 1; be_err_code = code;
        @(negedge clk); be_error = 0; be_err_code = 0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic data_reads(input int n);
        logic [15:0] d;
        for (int i = 0; i < n; i++) begin
            bus_rd(0, 3'd0, d);
            if (i == 0) chk("R5 data word", d, 16'hBEEF);
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        tests++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        wait_cyc(3);
        rst_n = 1;
        // R1: reset sequence
        bus_rd(1, 3'd6, d); chk("R1 busy after reset", d, 16'h0080);
        wait_cyc(10);
        bus_rd(0, 3'd7, d); chk("R1 ready status", d, 16'h0040);
        bus_rd(0, 3'd2, d); chk("R1 signature count", d, 16'h0001);
        bus_rd(0, 3'd3, d); chk("R1 signature sector", d, 16'h0001);
        bus_rd(0, 3'd4, d); chk("R1 signature cyl lo", d, 16'h0000);
        bus_rd(0, 3'd1, d); chk("R1 signature error", d, 16'h0001);

        // R2: command latch and start
        bus_wr(0, 3'd1, 16'h0011); bus_wr(0, 3'd2, 16'h0002); bus_wr(0, 3'd3, 16'h0033);
        bus_wr(0, 3'd4, 16'h0044); bus_wr(0, 3'd5, 16'h0055); bus_wr(0, 3'd6, 16'h00E0);
        bus_wr(0, 3'd7, 16'h0020);
        #2;
        chk("R2 cmd_start", {15'd0, cmd_start}, 16'd1);
        chk("R2 cmd_code", {8'd0, cmd_code}, 16'h0020);
        chk("R2 prm_feature", {8'd0, prm_feature}, 16'h0011);
        chk("R2 prm_count", {8'd0, prm_count}, 16'h0002);
        chk("R2 prm_sector", {8'd0, prm_sector}, 16'h0033);
        chk("R2 prm_cyl", prm_cyl, 16'h5544);
        chk("R2 prm_devhead", {8'd0, prm_devhead}, 16'h00E0);
        @(negedge clk); #2;
        chk("R2 single pulse", {15'd0, cmd_start}, 16'd0);

        // R3: busy read mask and ignored write
        bus_rd(0, 3'd2, d); chk("R3 busy read", d, 16'h0080);
        bus_wr(0, 3'd2, 16'h0099);
        bus_rd(1, 3'd6, d); chk("R3 alt while busy", d, 16'h00C0);

        // R7 / R10: completion and interrupt handling
        pulse_done();
        #2 chk("R7 intrq after done", {15'd0, intrq}, 16'd1);
        bus_rd(1, 3'd6, d); chk("R10 alt status", d, 16'h0040);
        #2 chk("R10 alt keeps irq", {15'd0, intrq}, 16'd1);
        bus_rd(0, 3'd7, d); chk("R10 status", d, 16'h0040);
        #2 chk("R10 status clears irq", {15'd0, intrq}, 16'd0);
        bus_rd(0, 3'd2, d); chk("R3 write ignored", d, 16'h0002);

        // R5 / R6: single-sector data phase
        bus_wr(0, 3'd7, 16'h0020);
        pulse_data(1'b0);
        bus_rd(1, 3'd6, d); chk("R5 drq status", d, 16'h0048);
        #2 chk("R5 irq on drq", {15'd0, intrq}, 16'd1);
        data_reads(255);
        bus_rd(1, 3'd6, d); chk("R6 drq before last", d, 16'h0048);
        data_reads(1);
        bus_rd(1, 3'd6, d); chk("R6 busy after last", d, 16'h00C0);
        pulse_done();

        // R12: set multiple, invalid then valid
        bus_wr(0, 3'd2, 16'h0003); bus_wr(0, 3'd7, 16'h00C6);
        #2 chk("R12 no start", {15'd0, cmd_start}, 16'd0);
        wait_cyc(1);
        bus_rd(0, 3'd7, d); chk("R12 invalid err", d, 16'h0041);
        bus_rd(0, 3'd1, d); chk("R12 abort code", d, 16'h0004);
        bus_wr(0, 3'd2, 16'h0002); bus_wr(0, 3'd7, 16'h00C6);
        wait_cyc(1);
        bus_rd(0, 3'd7, d); chk("R9 err cleared by command", d, 16'h0040);
        bus_wr(0, 3'd7, 16'h00C4);
        pulse_data(1'b1);
        data_reads(256);
        bus_rd(1, 3'd6, d); chk("R6 multi mid", d, 16'h0048);
        data_reads(256);
        bus_rd(1, 3'd6, d); chk("R6 multi end", d, 16'h00C0);
        pulse_done();
        bus_wr(0, 3'd2, 16'h0005); bus_wr(0, 3'd7, 16'h00C6);
        wait_cyc(1);
        bus_wr(0, 3'd7, 16'h00C4);
        pulse_data(1'b1);
        data_reads(256);
        bus_rd(1, 3'd6, d); chk("R12 size unchanged", d, 16'h0048);
        data_reads(256);
        pulse_done();

        // R8: error context
        bus_wr(0, 3'd2, 16'h0007); bus_wr(0, 3'd3, 16'h0008); bus_wr(0, 3'd4, 16'h0009);
        bus_wr(0, 3'd7, 16'h0030);
        pulse_error(8'h10);
        bus_rd(0, 3'd7, d); chk("R8 err status", d, 16'h0041);
        bus_rd(0, 3'd1, d); chk("R8 error code", d, 16'h0010);
        bus_rd(0, 3'd2, d); chk("R8 count kept", d, 16'h0007);
        bus_rd(0, 3'd3, d); chk("R8 sector kept", d, 16'h0008);
        bus_rd(0, 3'd4, d); chk("R8 cyl kept", d, 16'h0009);

        // R9: new command clears ERR
        bus_wr(0, 3'd7, 16'h0020);
        bus_rd(1, 3'd6, d); chk("R9 err cleared", d, 16'h00C0);

        // R4: soft reset during execution
        bus_wr(1, 3'd6, 16'h0004);
        bus_rd(1, 3'd6, d); chk("R4 soft reset status", d, 16'h0080);
        bus_wr(1, 3'd6, 16'h0000);
        wait_cyc(10);
        bus_rd(0, 3'd7, d); chk("R4 ready after release", d, 16'h0040);
        bus_rd(0, 3'd2, d); chk("R4 signature count", d, 16'h0001);

        // R11: interrupt mask
        bus_wr(1, 3'd6, 16'h0002);
        bus_wr(0, 3'd7, 16'h0020);
        pulse_done();
        #2 chk("R11 masked", {15'd0, intrq}, 16'd0);
        bus_wr(1, 3'd6, 16'h0000);
        #2 chk("R11 unmasked pending", {15'd0, intrq}, 16'd1);

        wait_cyc(2);
        finish_run();
    end

endmodule